// File: doc/BRIEF.md
# Split-Capable Load/Store Unit

This unit executes one decoded memory operation at a time for a 64-bit integer core. A request gives a load/store flag, an access size, a zero-extend flag for loads, a base register value, a 12-bit signed offset and store data. The unit forms the effective address, drives a 64-bit aligned memory bus with per-byte write enables, and returns a load result that has been lane-aligned and then sign- or zero-extended to 64 bits.

An access whose bytes do not fit inside one 8-byte line is not trapped. The unit issues two aligned bus beats, one at the line holding the first byte and one at the next line. It stitches the returned bytes together for a load, or spreads the write enables across both beats for a store. `busy` stays high from acceptance through the one-cycle `done` pulse. Requests that arrive during that window are dropped.

The bus uses a request/ready handshake. A read beat is answered by a single-cycle `bus_rvalid` pulse that comes no earlier than the cycle after the handshake.

Top module: `mem_access_unit`

## Requirements
- R1: The effective address is `req_base` plus `req_imm` sign-extended from 12 bits, modulo 2^64. The first bus beat uses that address with its low 3 bits cleared, and every bus address is 8-byte aligned.
- R2: Signed loads (`req_unsigned`=0) of byte, halfword and word (`req_size` 0, 1, 2) copy bit 7, 15 or 31 of the loaded value into all higher result bits.
- R3: Unsigned loads (`req_unsigned`=1) of byte, halfword and word fill all higher result bits with zero.
- R4: A doubleword load (`req_size`=3) returns the 8 bytes starting at the effective address unchanged, whatever the value of `req_unsigned`.
- R5: A store (`req_store`=1) writes exactly 1, 2, 4 or 8 bytes (`req_size` 0..3), taken from the low bytes of `req_wdata`. Each lands at effective address + i, and upper source bits are ignored. `bus_be` bit k enables byte lane k, the lane for address byte offset k.
- R6: When (effective address mod 8) + size in bytes is at most 8, the access uses exactly one bus beat. Byte accesses therefore always use one beat.
- R7: When that sum exceeds 8, the access uses exactly two beats. The second beat's address is the first beat's address plus 8, wrapping modulo 2^64. A load result merges bytes from both beats.
- R8: `busy` rises in the cycle after acceptance. `done` is a one-cycle pulse with `busy` still high, and it comes in the cycle after the last beat completes. A store beat completes at its ready handshake, and a load beat completes when its `bus_rvalid` pulse is sampled.
- R9: `req_valid` is ignored while `busy` is high, and no bus request is made while `busy` is low.
- R10: During and just after reset, `busy`, `done` and `bus_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation present; accepted when not busy |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_unsigned | input | 1 | Load result is zero-extended when set |
| req_base | input | 64 | Base register value |
| req_imm | input | 12 | Signed offset |
| req_wdata | input | 64 | Store source register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Extended load result, valid with `done` |
| bus_req | output | 1 | Bus beat request |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | 64 | 8-byte aligned beat address |
| bus_be | output | 8 | Byte-lane write enables |
| bus_wdata | output | 64 | Lane-positioned write data |
| bus_ready | input | 1 | Bus accepts the beat |
| bus_rvalid | input | 1 | Read data valid pulse |
| bus_rdata | input | 64 | Read data for the beat |

## Verification
The bench builds the unit with its defaults: 64-bit registers and a 12-bit offset. This places both offset extremes (-2048 and +2047) within reach, and lets a doubleword start at any of the 8 byte offsets, so every size and offset pair that does or does not straddle a line can be driven. The 64-bit address width also lets a doubleword just below the top of the address space wrap its second beat to line zero. A bus model that stalls `bus_ready` on some cycles keeps request-hold behaviour and the done timing under load.

// File: rtl/mau_pkg.sv
`timescale 1ns/1ps
package mau_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BEAT0,
        ST_WAIT0,
        ST_BEAT1,
        ST_WAIT1,
        ST_DONE
    } mau_state_e;

    typedef struct packed {
        logic  store;
        size_e size;
        logic  unsgn;
        logic  split;
    } op_attr_t;

    function automatic int unsigned size_bytes(size_e s);
        return 32'd1 << s;
    endfunction

endpackage

// File: rtl/mau_agu.sv
`timescale 1ns/1ps
module mau_agu
    import mau_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 12,
    parameter int LANES = XLEN / 8,
    parameter int OFF_W = $clog2(LANES)
) (
    input  logic [XLEN-1:0]    base,
    input  logic [IMM_W-1:0]   imm,
    input  size_e              size,
    input  logic [XLEN-1:0]    wdata,
    output logic [XLEN-1:0]    line_addr,
    output logic [OFF_W-1:0]   offset,
    output logic               split,
    output logic [2*LANES-1:0] pair_be,
    output logic [2*XLEN-1:0]  pair_data
);

    logic [XLEN-1:0]  eff;
    logic [OFF_W:0]   nbytes;
    logic [LANES-1:0] keep;
    logic [XLEN-1:0]  keep_bits;

    assign eff       = base + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign nbytes    = (OFF_W+1)'(size_bytes(size));
    assign offset    = eff[OFF_W-1:0];
    assign line_addr = {eff[XLEN-1:OFF_W], {OFF_W{1'b0}}};
    assign split     = ({1'b0, offset} + nbytes) > (OFF_W+1)'(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_keep
        assign keep[i]            = (OFF_W+1)'(i) < nbytes;
        assign keep_bits[i*8 +: 8] = {8{keep[i]}};
    end

    assign pair_be   = {{LANES{1'b0}}, keep} << offset;
    assign pair_data = {{XLEN{1'b0}}, wdata & keep_bits} << {offset, 3'b000};

endmodule

// File: rtl/mau_load_align.sv
`timescale 1ns/1ps
module mau_load_align
    import mau_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LANES = XLEN / 8,
    parameter int OFF_W = $clog2(LANES)
) (
    input  logic [2*XLEN-1:0] line_pair,
    input  logic [OFF_W-1:0]  offset,
    input  size_e             size,
    input  logic              unsgn,
    output logic [XLEN-1:0]   result
);

    logic [2*XLEN-1:0] shifted;
    logic [XLEN-1:0]   low;
    logic              fill;
    int unsigned       nbits;

    assign shifted = line_pair >> {offset, 3'b000};
    assign low     = shifted[XLEN-1:0];

    always_comb begin
        nbits = size_bytes(size) * 8;
        if (nbits > XLEN) nbits = XLEN;
        fill = ~unsgn & low[nbits-1];
        for (int i = 0; i < XLEN; i++) begin
            result[i] = (i < nbits) ? low[i] : fill;
        end
    end

endmodule

// File: rtl/mau_ctrl.sv
`timescale 1ns/1ps
module mau_ctrl
    import mau_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic is_store,
    input  logic split,
    input  logic bus_ready,
    input  logic bus_rvalid,
    output logic busy,
    output logic done,
    output logic bus_req,
    output logic beat_hi,
    output logic cap_lo,
    output logic cap_hi
);

    mau_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt    = state;
        cap_lo = 1'b0;
        cap_hi = 1'b0;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_BEAT0;
            ST_BEAT0: if (bus_ready) begin
                          if (!is_store) nxt = ST_WAIT0;
                          else           nxt = split ? ST_BEAT1 : ST_DONE;
                      end
            ST_WAIT0: if (bus_rvalid) begin
                          cap_lo = 1'b1;
                          nxt    = split ? ST_BEAT1 : ST_DONE;
                      end
            ST_BEAT1: if (bus_ready) nxt = is_store ? ST_DONE : ST_WAIT1;
            ST_WAIT1: if (bus_rvalid) begin
                          cap_hi = 1'b1;
                          nxt    = ST_DONE;
                      end
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);
    assign bus_req = (state == ST_BEAT0) || (state == ST_BEAT1);
    assign beat_hi = (state == ST_BEAT1) || (state == ST_WAIT1);

endmodule

// File: rtl/mem_access_unit.sv
`timescale 1ns/1ps
module mem_access_unit
    import mau_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              req_unsigned,
    input  logic [XLEN-1:0]   req_base,
    input  logic [IMM_W-1:0]  req_imm,
    input  logic [XLEN-1:0]   req_wdata,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   rdata,
    output logic              bus_req,
    output logic              bus_we,
    output logic [XLEN-1:0]   bus_addr,
    output logic [XLEN/8-1:0] bus_be,
    output logic [XLEN-1:0]   bus_wdata,
    input  logic              bus_ready,
    input  logic              bus_rvalid,
    input  logic [XLEN-1:0]   bus_rdata
);

    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    logic               start, beat_hi, cap_lo, cap_hi;
    logic [XLEN-1:0]    agu_line;
    logic [OFF_W-1:0]   agu_off;
    logic               agu_split;
    logic [2*LANES-1:0] agu_be;
    logic [2*XLEN-1:0]  agu_data;

    op_attr_t           attr_q;
    logic [XLEN-1:0]    line_q;
    logic [OFF_W-1:0]   off_q;
    logic [2*LANES-1:0] be_q;
    logic [2*XLEN-1:0]  wd_q;
    logic [2*XLEN-1:0]  rd_q;

    assign start = req_valid && !busy;

    mau_agu #(.XLEN(XLEN), .IMM_W(IMM_W), .LANES(LANES), .OFF_W(OFF_W)) u_agu (
        .base      (req_base),
        .imm       (req_imm),
        .size      (size_e'(req_size)),
        .wdata     (req_wdata),
        .line_addr (agu_line),
        .offset    (agu_off),
        .split     (agu_split),
        .pair_be   (agu_be),
        .pair_data (agu_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            attr_q <= '0;
            line_q <= '0;
            off_q  <= '0;
            be_q   <= '0;
            wd_q   <= '0;
            rd_q   <= '0;
        end else begin
            if (start) begin
                attr_q.store <= req_store;
                attr_q.size  <= size_e'(req_size);
                attr_q.unsgn <= req_unsigned;
                attr_q.split <= agu_split;
                line_q       <= agu_line;
                off_q        <= agu_off;
                be_q         <= agu_be;
                wd_q         <= agu_data;
                rd_q         <= '0;
            end
            if (cap_lo) rd_q[XLEN-1:0]      <= bus_rdata;
            if (cap_hi) rd_q[2*XLEN-1:XLEN] <= bus_rdata;
        end
    end

    mau_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .is_store   (attr_q.store),
        .split      (attr_q.split),
        .bus_ready  (bus_ready),
        .bus_rvalid (bus_rvalid),
        .busy       (busy),
        .done       (done),
        .bus_req    (bus_req),
        .beat_hi    (beat_hi),
        .cap_lo     (cap_lo),
        .cap_hi     (cap_hi)
    );

    assign bus_we    = attr_q.store;
    assign bus_addr  = beat_hi ? line_q + XLEN'(LANES) : line_q;
    assign bus_be    = beat_hi ? be_q[2*LANES-1:LANES] : be_q[LANES-1:0];
    assign bus_wdata = beat_hi ? wd_q[2*XLEN-1:XLEN]   : wd_q[XLEN-1:0];

    mau_load_align #(.XLEN(XLEN), .LANES(LANES), .OFF_W(OFF_W)) u_align (
        .line_pair (rd_q),
        .offset    (off_q),
        .size      (attr_q.size),
        .unsgn     (attr_q.unsgn),
        .result    (rdata)
    );

endmodule

// File: rtl/mau_checker.sv
`timescale 1ns/1ps
module mau_checker #(
    parameter int XLEN = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              bus_req,
    input logic              bus_ready,
    input logic [XLEN-1:0]   bus_addr,
    input logic [XLEN/8-1:0] bus_be
);

    localparam int LANES = XLEN / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [1:0]      beat_cnt;
    logic [XLEN-1:0] first_addr;
    logic            rst_q;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst || done) begin
            beat_cnt   <= '0;
            first_addr <= '0;
        end else if (bus_req && bus_ready) begin
            beat_cnt <= beat_cnt + 2'd1;
            if (beat_cnt == 2'd0) first_addr <= bus_addr;
        end
    end

    AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_addr[OFF_W-1:0] == '0)); // R1

    AST_BEAT_HELD: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_be))); // R1

    AST_LANES_ENABLED: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> (bus_be != '0)); // R5

    AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (rst)
        done |-> (beat_cnt == 2'd1 || beat_cnt == 2'd2)); // R6

    AST_NEXT_LINE: assert property (@(posedge clk) disable iff (rst)
        (bus_req && beat_cnt == 2'd1) |-> (bus_addr == first_addr + XLEN'(LANES))); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> busy); // R8

    AST_IDLE_NO_BUS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req); // R9

    always @(posedge clk) begin
        if (rst_q) begin
            AST_RESET_QUIET: assert (!busy && !done && !bus_req); // R10
        end
    end

endmodule

bind mem_access_unit mau_checker #(.XLEN(XLEN)) u_mau_checker (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .bus_req   (bus_req),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be)
);

// File: tb/mem_access_unit_bench.sv
`timescale 1ns/1ps
module mem_access_unit_bench;

    localparam int MEMB = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [63:0] req_base = '0, req_wdata = '0;
    logic [11:0] req_imm = '0;
    logic        busy, done, bus_req, bus_we;
    logic [63:0] rdata, bus_addr, bus_wdata;
    logic [7:0]  bus_be;
    logic        bus_ready = 1'b0, bus_rvalid = 1'b0;
    logic [63:0] bus_rdata = '0;

    always #2 clk = ~clk;

    mem_access_unit u_mem_access_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
        .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
        .req_imm(req_imm), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rdata(rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    typedef struct {
        bit          is_load;
        logic [63:0] value;
        int          beats;
        logic [63:0] a0;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [7:0]  ref_mem [MEMB];
    logic [63:0] smem [MEMB/8];
    int          n_checks = 0, n_fail = 0, cyc = 0, last_evt = -10;
    int          seen_beats = 0;
    logic [63:0] seen_a [2];
    bit          pend_hs = 0, pend_we = 0;
    logic [63:0] pend_addr, pend_wd;
    logic [7:0]  pend_be;

    function automatic void chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    initial begin
        for (int j = 0; j < MEMB; j++) ref_mem[j] = 8'((j * 73 + 5) & 255);
        for (int w = 0; w < MEMB/8; w++)
            for (int b = 0; b < 8; b++) smem[w][b*8 +: 8] = ref_mem[w*8 + b];
    end

    // bus model and result monitor
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            bus_ready  = 1'b0;
            bus_rvalid = 1'b0;
            pend_hs    = 0;
            seen_beats = 0;
        end else begin
            bus_rvalid = 1'b0;
            if (pend_hs) begin
                if (pend_we) begin
                    for (int b = 0; b < 8; b++)
                        if (pend_be[b]) smem[pend_addr[8:3]][b*8 +: 8] = pend_wd[b*8 +: 8];
                end else begin
                    bus_rvalid = 1'b1;
                    bus_rdata  = smem[pend_addr[8:3]];
                    last_evt   = cyc;
                end
                pend_hs = 0;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    chk(0, "R9 unexpected done", 64'(seen_beats), 64'd0);
                end else begin
                    exp_t e;
                    bit   same;
                    e = sb.pop_front();
                    chk(cyc == last_evt + 1, "R8 done timing", 64'(cyc), 64'(last_evt + 1));
                    chk(seen_beats == e.beats, (e.beats == 2) ? "R7 beat count" : "R6 beat count",
                        64'(seen_beats), 64'(e.beats));
                    chk(seen_a[0] == e.a0, "R1 first beat address", seen_a[0], e.a0);
                    if (e.beats == 2 && seen_beats == 2)
                        chk(seen_a[1] == e.a0 + 64'd8, "R7 second beat address", seen_a[1], e.a0 + 64'd8);
                    if (e.is_load) begin
                        chk(rdata == e.value, e.tag, rdata, e.value);
                    end else begin
                        same = 1;
                        for (int j = 0; j < MEMB; j++)
                            if (smem[j/8][(j%8)*8 +: 8] !== ref_mem[j]) same = 0;
                        chk(same, e.tag, 64'(same), 64'd1);
                    end
                end
                seen_beats = 0;
            end
            bus_ready = bus_req && (cyc % 3 != 0);
            if (bus_req && bus_ready) begin
                pend_hs   = 1;
                pend_we   = bus_we;
                pend_addr = bus_addr;
                pend_wd   = bus_wdata;
                pend_be   = bus_be;
                if (seen_beats < 2) seen_a[seen_beats] = bus_addr;
                seen_beats++;
                if (bus_we) last_evt = cyc;
            end
        end
    end

    task automatic do_op(input bit st, input logic [1:0] sz, input bit uns,
                         input logic [63:0] base, input logic [11:0] imm,
                         input logic [63:0] wd, input string tag, input bit inject);
        exp_t        e;
        logic [63:0] ea, val;
        logic [8:0]  idx;
        int          nb;
        @(negedge clk);
        while (busy || sb.size() != 0) @(negedge clk);
        ea  = base + {{52{imm[11]}}, imm};
        nb  = 1 << sz;
        val = '0;
        for (int i = 0; i < nb; i++) begin
            idx = ea[8:0] + 9'(i);
            if (st) ref_mem[idx] = wd[i*8 +: 8];
            else    val[i*8 +: 8] = ref_mem[idx];
        end
        if (!st && !uns && nb < 8 && val[nb*8-1])
            for (int i = nb*8; i < 64; i++) val[i] = 1'b1;
        e.is_load = !st;
        e.value   = val;
        e.beats   = (int'(ea[2:0]) + nb > 8) ? 2 : 1;
        e.a0      = {ea[63:3], 3'b000};
        e.tag     = tag;
        sb.push_back(e);
        req_store = st; req_size = sz; req_unsigned = uns;
        req_base = base; req_imm = imm; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
        if (inject) begin
            // R9: a different request while busy must leave no trace
            req_store = 1'b1; req_size = 2'd3; req_base = 64'h40; req_imm = '0;
            req_wdata = 64'hDEAD_BEEF_0BAD_F00D;
            @(negedge clk);
        end
        req_valid = 1'b0;
    endtask

    bit timed_out = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && !bus_req, "R10 reset state", {61'd0, busy, done, bus_req}, 64'd0);
        fork
            begin
                // R2 R3 R4 R6 R7: every size, offset and extension
                for (int sz = 0; sz < 4; sz++)
                    for (int off = 0; off < 8; off++)
                        for (int u = 0; u < 2; u++)
                            do_op(0, 2'(sz), u[0], 64'h100, 12'(off + 24*sz),
                                  '0, (sz == 3) ? "R4 doubleword load" :
                                      (u == 1 ? "R3 zero-extended load" : "R2 sign-extended load"), 0);
                // R5: stores of every size and offset with junk upper source bits
                for (int sz = 0; sz < 4; sz++)
                    for (int off = 0; off < 8; off++)
                        do_op(1, 2'(sz), 0, 64'h180 + 64'(off), 12'(sz * 16),
                              64'hF1E2_D3C4_B5A6_9788 ^ 64'(off * 4099), "R5 store bytes", 0);
                // R7: merged load back across a line written by split stores
                do_op(0, 2'd3, 0, 64'h18D, 12'd0, '0, "R7 merged doubleword", 0);
                // R1: offset extremes
                do_op(0, 2'd2, 0, 64'h900, 12'h800, '0, "R1 offset -2048", 0);
                do_op(0, 2'd1, 1, 64'h0, 12'h7FF, '0, "R1 offset +2047", 0);
                do_op(1, 2'd1, 0, 64'h1005, 12'h7FA, 64'hFFFF_FFFF_FFFF_5A3C, "R5 store at +2042", 0);
                // R7: second beat wraps past the top of the address space
                do_op(0, 2'd3, 0, 64'hFFFF_FFFF_FFFF_FFFC, 12'd0, '0, "R7 wrap load", 0);
                do_op(1, 2'd2, 0, 64'hFFFF_FFFF_FFFF_FFFE, 12'd0, 64'h0123_4567_89AB_CDEF, "R7 wrap store", 0);
                // R9: requests during busy are dropped
                do_op(0, 2'd1, 0, 64'h107, 12'd0, '0, "R9 load with busy-time request", 1);
                do_op(0, 2'd3, 0, 64'h40, 12'd0, '0, "R9 target line untouched", 0);
                repeat (20) @(negedge clk);
            end
            begin
                repeat (100000) @(negedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) chk(0, "watchdog", 64'(cyc), 64'd0);
        chk(sb.size() == 0, "R8 all operations completed", 64'(sb.size()), 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule